// File: doc/BRIEF.md
# Tag Group Completion Tracker

This block keeps an outstanding-operation count for each of 32 transfer tag groups and answers software questions about which groups have drained. Commands reach it on an issue port with a group number and two ordering flags. A command is handed to the execution engine only when its ordering rules allow it. Each handed-over command raises its group's count. A completion port lowers the count of a group when one of its transfers finishes.

Software first writes a 32-bit group mask, with one bit per group, and then a query mode. It then holds a status read request until the block answers. The answer is the masked set of groups whose count is zero. In the immediate mode the answer comes in the same cycle, and it may be all zeros. In the "any" mode the answer is held back until at least one masked group is idle. In the "all" mode it is held back until every masked group is idle. A held read is answered in the first cycle its condition is true.

A fenced command waits until every earlier command in its group has completed. A barrier command waits for the same condition. It also holds back every later command of its group until the barrier itself has completed. Commands with neither flag may complete in any order.

Top module: `tag_group_tracker`

## Requirements
- R1: After reset every group count is zero, the mask is zero and the mode is immediate. A plain command is therefore accepted, and a status read is answered at once with the value 0.
- R2: An accepted command (cmd_valid and cmd_ready both high) raises its group's count by one. A completion lowers the named group's count by one. A completion for a group whose count is zero is ignored. A group is idle exactly when its count is zero.
- R3: An accepted command and a completion to the same non-idle group in one cycle leave that group's count unchanged.
- R4: A group holds at most MAX_OUT (16) outstanding commands. cmd_ready is low for any command to a group whose count is 16.
- R5: Mode code 0 (immediate) answers a read in the same cycle stat_rd is high, with stat_data set to mask AND idle groups.
- R6: Mode code 1 (any) raises stat_valid only while at least one masked group is idle. With an all-zero mask it never answers.
- R7: Mode code 2 (all) raises stat_valid only while every masked group is idle. With an all-zero mask it answers at once with 0.
- R8: stat_data never shows a group outside the mask.
- R9: A command with the fence flag is accepted only when its group is idle.
- R10: A command with the barrier flag is accepted only when its group is idle. After it is accepted, no command of that group is accepted until the group's count returns to zero.
- R11: A plain command to a group with no pending barrier and fewer than 16 outstanding is accepted regardless of earlier outstanding commands.
- R12: Mode code 3 behaves as the immediate mode. Mask and mode writes take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_tag | input | 5 | Group of the offered command |
| cmd_fence | input | 1 | Fence ordering flag |
| cmd_barrier | input | 1 | Barrier ordering flag |
| cmd_ready | output | 1 | Command may be released to the engine |
| done_valid | input | 1 | A transfer has completed |
| done_tag | input | 5 | Group of the completed transfer |
| mask_wr | input | 1 | Load mask_in into the query mask |
| mask_in | input | 32 | New query mask |
| mode_wr | input | 1 | Load mode_in into the query mode |
| mode_in | input | 2 | New query mode |
| stat_rd | input | 1 | Status read request, held until answered |
| stat_valid | output | 1 | Status read answered this cycle |
| stat_data | output | 32 | Masked idle groups |

## Verification
The hardest state to reach from the ports is a group sitting at exactly 16 outstanding commands. At that point, same-cycle issue and completion traffic and a pending barrier must all be judged together. Random traffic rarely drains slowly enough to get there. The stimulus therefore funnels commands into four groups and alternates issue-heavy and drain-heavy phases. Directed sequences fill one group to its limit, test the cancel case, and walk a barrier through its hold-off while other groups stay free.

// File: rtl/tag_group_tracker.sv
module tag_group_tracker #(
  parameter int NGRP    = 32,
  parameter int MAX_OUT = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [$clog2(NGRP)-1:0] cmd_tag,
  input  logic                    cmd_fence,
  input  logic                    cmd_barrier,
  output logic                    cmd_ready,
  input  logic                    done_valid,
  input  logic [$clog2(NGRP)-1:0] done_tag,
  input  logic                    mask_wr,
  input  logic [NGRP-1:0]         mask_in,
  input  logic                    mode_wr,
  input  logic [1:0]              mode_in,
  input  logic                    stat_rd,
  output logic                    stat_valid,
  output logic [NGRP-1:0]         stat_data
);
  localparam int TAG_W = $clog2(NGRP);
  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam logic [1:0] MODE_ANY = 2'd1;
  localparam logic [1:0] MODE_ALL = 2'd2;

  logic [CNT_W-1:0] cnt_q [NGRP];
  logic [NGRP-1:0]  idle, bar_q, masked;
  logic [NGRP-1:0]  mask_q;
  logic [1:0]       mode_q;
  logic             issue, sel_full, sel_hold, cond;

  assign sel_full  = cnt_q[cmd_tag] == CNT_W'(MAX_OUT);
  assign sel_hold  = bar_q[cmd_tag] && !idle[cmd_tag];
  assign cmd_ready = !sel_full && !sel_hold &&
                     (!(cmd_fence || cmd_barrier) || idle[cmd_tag]);
  assign issue     = cmd_valid && cmd_ready;

  for (genvar g = 0; g < NGRP; g++) begin : grp
    logic inc, dec;
    assign inc     = issue && cmd_tag == TAG_W'(g);
    assign dec     = done_valid && done_tag == TAG_W'(g) && !idle[g];
    assign idle[g] = cnt_q[g] == '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
        bar_q[g] <= 1'b0;
      end else begin
        if (inc && !dec)      cnt_q[g] <= cnt_q[g] + CNT_W'(1);
        else if (dec && !inc) cnt_q[g] <= cnt_q[g] - CNT_W'(1);
        if (inc && cmd_barrier) bar_q[g] <= 1'b1;
        else if (idle[g])       bar_q[g] <= 1'b0;
      end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] <= CNT_W'(MAX_OUT)); // R4
    AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && done_valid && done_tag == TAG_W'(g) && cnt_q[g] != '0) |=> $stable(cnt_q[g])); // R3
    AST_BAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_q[g] && cnt_q[g] != '0) |-> !inc); // R10
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
    end else begin
      if (mask_wr) mask_q <= mask_in;
      if (mode_wr) mode_q <= mode_in;
    end
  end

  assign masked = idle & mask_q;

  always_comb begin
    case (mode_q)
      MODE_ANY: cond = |masked;
      MODE_ALL: cond = masked == mask_q;
      default:  cond = 1'b1;
    endcase
  end

  assign stat_valid = stat_rd && cond;
  assign stat_data  = masked;

  AST_FENCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (cmd_fence || cmd_barrier)) |-> idle[cmd_tag]); // R9
  AST_ANY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && mode_q == MODE_ANY) |-> stat_data != '0); // R6
  AST_ALL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && mode_q == MODE_ALL) |-> stat_data == mask_q); // R7
  AST_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_data & ~mask_q) == '0); // R8
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> mask_q == $past(mask_in)); // R12
endmodule

// File: tb/tag_group_tracker_test.sv
module tag_group_tracker_test;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_fence = 0, cmd_barrier = 0, done_valid = 0;
  logic [4:0] cmd_tag = 0, done_tag = 0;
  logic mask_wr = 0, mode_wr = 0, stat_rd = 0;
  logic [31:0] mask_in = 0;
  logic [1:0] mode_in = 0;
  logic cmd_ready, stat_valid;
  logic [31:0] stat_data;

  int errors = 0, checks = 0;
  int cnt_m [32];
  bit bp_m [32];
  logic [31:0] mask_m = 0;
  logic [1:0] mode_m = 0;

  always #2 clk = ~clk;

  tag_group_tracker uut (.*);

  function automatic logic [31:0] idle_v();
    logic [31:0] v;
    for (int g = 0; g < 32; g++) v[g] = (cnt_m[g] == 0);
    return v;
  endfunction

  function automatic bit exp_ready(int t, bit f, bit b);
    return cnt_m[t] < 16 && !(bp_m[t] && cnt_m[t] != 0) && (!(f || b) || cnt_m[t] == 0);
  endfunction

  function automatic bit exp_cond();
    logic [31:0] m;
    m = idle_v() & mask_m;
    if (mode_m == 2'd1) return |m;
    if (mode_m == 2'd2) return m == mask_m;
    return 1'b1;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit cv, int ct, bit cf, bit cb, bit dv, int dt,
                      bit mw, logic [31:0] mv, bit ow, logic [1:0] ov, bit rd);
    bit er, esv;
    logic [31:0] esd;
    string lab;
    @(negedge clk);
    cmd_valid = cv; cmd_tag = 5'(ct); cmd_fence = cf; cmd_barrier = cb;
    done_valid = dv; done_tag = 5'(dt);
    mask_wr = mw; mask_in = mv; mode_wr = ow; mode_in = ov; stat_rd = rd;
    #1;
    er = exp_ready(ct, cf, cb);
    if (cnt_m[ct] >= 16) lab = "R4";
    else if (bp_m[ct] && cnt_m[ct] != 0) lab = "R10";
    else if (cb) lab = "R10";
    else if (cf) lab = "R9";
    else lab = "R11";
    check(cmd_ready === er, lab, {31'd0, cmd_ready}, {31'd0, er});
    esv = rd && exp_cond();
    esd = idle_v() & mask_m;
    lab = (mode_m == 2'd1) ? "R6" : (mode_m == 2'd2) ? "R7" : (mode_m == 2'd3) ? "R12" : "R5";
    check(stat_valid === esv, lab, {31'd0, stat_valid}, {31'd0, esv});
    if (esv) check(stat_data === esd, (mask_m == '1) ? "R2" : "R8", stat_data, esd);
    begin
      bit inc, dec;
      for (int g = 0; g < 32; g++) begin
        inc = cv && er && ct == g;
        dec = dv && dt == g && cnt_m[g] != 0;
        if (inc && cb) bp_m[g] = 1;
        else if (cnt_m[g] == 0) bp_m[g] = 0;
        cnt_m[g] = cnt_m[g] + int'(inc) - int'(dec);
      end
    end
    if (mw) mask_m = mv;
    if (ow) mode_m = ov;
  endtask

  task automatic idle_step(bit rd);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, rd);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd7);
    for (int g = 0; g < 32; g++) begin cnt_m[g] = 0; bp_m[g] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    @(negedge clk); stat_rd = 1; #1;
    check(stat_valid === 1'b1 && stat_data === 32'd0, "R1", stat_data, 32'd0);
    check(cmd_ready === 1'b1, "R1", {31'd0, cmd_ready}, 32'd1);
    stat_rd = 0;
    // full mask, immediate
    step(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, 1, 2'd0, 0);
    // R3 cancel
    step(1, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 5, 0, 0, 1, 5, 0, 0, 0, 0, 0);
    idle_step(1);
    check(stat_data[5] === 1'b0 && cnt_m[5] == 1, "R3", {31'd0, stat_data[5]}, 32'd0);
    step(0, 0, 0, 0, 1, 5, 0, 0, 0, 0, 0);
    idle_step(1);
    check(stat_data[5] === 1'b1, "R3", {31'd0, stat_data[5]}, 32'd1);
    // R2 completion to idle group ignored, then issue counts
    step(0, 0, 0, 0, 1, 9, 0, 0, 0, 0, 0);
    step(1, 9, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle_step(1);
    check(stat_data[9] === 1'b0, "R2", {31'd0, stat_data[9]}, 32'd0);
    step(0, 0, 0, 0, 1, 9, 0, 0, 0, 0, 0);
    // R4 fill group 3 to the limit
    for (int i = 0; i < 17; i++) step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check(cnt_m[3] == 16, "R4", cnt_m[3], 16);
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 1, 3, 0, 0, 0, 0, 0);
    // R10 barrier hold-off, R9 fence
    step(1, 7, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 7, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 7, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 7, 0, 0, 0, 0, 0);
    step(1, 7, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 7, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 7, 0, 0, 0, 0, 0);
    step(1, 7, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 7, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 8, 0, 0, 0, 0, 0);
    // R6/R7 empty mask
    step(0, 0, 0, 0, 0, 0, 1, 32'd0, 1, 2'd1, 0);
    idle_step(1);
    check(stat_valid === 1'b0, "R6", {31'd0, stat_valid}, 32'd0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 0);
    idle_step(1);
    check(stat_valid === 1'b1 && stat_data === 0, "R7", stat_data, 32'd0);
    // R7 stall then release in first true cycle
    step(1, 2, 0, 0, 0, 0, 1, 32'h0000_000C, 0, 0, 0);
    step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 2, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 3, 0, 0, 0, 0, 1);
    idle_step(1);
    check(stat_valid === 1'b1 && stat_data === 32'hC, "R7", stat_data, 32'hC);
    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      for (int i = 0; i < 200; i++) begin
        bit heavy;
        heavy = ph[0];
        step(($urandom % 4) != 0,
             ($urandom % 8 == 0) ? int'($urandom % 32) : int'($urandom % 4),
             ($urandom % 10) == 0, ($urandom % 14) == 0,
             heavy ? (($urandom % 5) == 0) : (($urandom % 5) != 0),
             ($urandom % 8 == 0) ? int'($urandom % 32) : int'($urandom % 4),
             ($urandom % 25) == 0, ($urandom % 2) ? 32'h0000_000F & $urandom : $urandom,
             ($urandom % 20) == 0, 2'($urandom), ($urandom % 2) == 0);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule